// File: doc/BRIEF.md
# Serial EEPROM ID Autoloader

This block fills three identification registers (vendor ID, subsystem vendor ID and model number) from a small serial EEPROM with 16-bit words, accessed over the common four-wire microwire-style link. The block leaves reset in a presence-sense window. During that window the chip-select driver is released, so an external pull-up on that line can signal that a part is fitted. If the pin reads high, the block issues three read commands to addresses 0, 1 and 2 in turn. Each read shifts the returned word into the matching ID register. If the pin reads low, the built-in default IDs stay in place.

During the autoload the serial clock is the system clock divided by `CLK_DIV`. Each serial bit occupies one slot of `CLK_DIV` cycles: the clock is low for the first half of the slot and high for the second half. Outgoing bits change at the start of a slot, which is the falling clock edge. Incoming bits are captured on the rising edge. After the last word is stored the block raises `load_done` and gives the four EEPROM pins to a three-bit manual register. Software can then bit-bang the part through that register and read the data-in level back.

The controller is a state machine with these states:
- `ST_SENSE`: one slot with chip select released. At the end of the slot it goes to `ST_GAP` if the sensed line is high, or to `ST_DONE` if it is low.
- `ST_GAP`: one slot with chip select low. It then goes to `ST_CMD`.
- `ST_CMD`: start bit, read opcode and address, one slot per bit. It then goes to `ST_DUMMY`.
- `ST_DUMMY`: one slot during which the part returns its leading zero. It then goes to `ST_DATA`.
- `ST_DATA`: 16 data slots. It then goes to `ST_STORE`.
- `ST_STORE`: one cycle that writes the word. It goes to `ST_GAP` for the next word, or to `ST_DONE` after word 2.
- `ST_DONE`: terminal state, left only by reset.

`CLK_DIV` must be even and at least 4.

Top module: `eeprom_id_loader`

## Requirements
- R1: While `rst_n` is low, `load_done` is 0, `ee_sk` and `ee_cs` are 0, `ee_cs_oe` is 0, and the ID outputs hold the default parameter values.
- R2: For the first `CLK_DIV` cycles after reset, `ee_cs_oe` is 0 and `ee_sk` is 0. `ee_cs_in` is sampled at the end of this window. If it is 0, `load_done` rises `CLK_DIV` cycles after reset release, the default IDs are kept, and `ee_sk` never pulses.
- R3: During the autoload, consecutive rising edges of `ee_sk` within one chip-select frame are `CLK_DIV` cycles apart. Each high phase lasts `CLK_DIV/2` cycles. `ee_sk` is 0 whenever `ee_cs` is 0. Each frame has exactly 26 rising edges.
- R4: Each frame starts by sending 9 bits on `ee_do`, MSB first: start bit 1, opcode bits 1 then 0, then the 6-bit word address. `ee_do` changes only while `ee_sk` is low.
- R5: After the command, one rising edge is skipped for the dummy zero. The next 16 rising edges capture `ee_di`, MSB first, as the data word.
- R6: Words are read from addresses 0, 1 and 2, in that order, into `vendor_id`, `subsys_id` and `model_id`.
- R7: Between word reads, `ee_cs` stays low for at least `CLK_DIV` cycles.
- R8: When an EEPROM is present, `load_done` rises exactly `CLK_DIV + 3*(27*CLK_DIV+1)` cycles after reset release, in the same cycle that the last word appears. From then on it stays 1 and the IDs do not change.
- R9: Once `load_done` is 1, a write with `man_we` stores `man_wdata`: bit 0 drives `ee_sk`, bit 1 drives `ee_cs`, bit 2 drives `ee_do`. The new levels appear in the next cycle, `ee_cs_oe` stays 1, and `man_rdata` reads {`ee_di`, do, cs, sk} in bits 3..0.
- R10: Writes while `load_done` is 0 are ignored. The manual bits stay 0 and do not reach the pins after handover.
- R11: Asserting reset in the middle of a load abandons it. After release, the load starts again from `ST_SENSE` and completes with the full R8 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ee_di | input | 1 | Serial data returned by the EEPROM |
| ee_cs_in | input | 1 | Level sensed on the chip-select pin |
| man_we | input | 1 | Manual pin register write strobe |
| man_wdata | input | 3 | Manual register data {do, cs, sk} |
| vendor_id | output | WORD_W | Loaded vendor ID (word 0) |
| subsys_id | output | WORD_W | Loaded subsystem vendor ID (word 1) |
| model_id | output | WORD_W | Loaded model number (word 2) |
| load_done | output | 1 | Autoload finished, pins handed to the manual register |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_cs | output | 1 | EEPROM chip select |
| ee_cs_oe | output | 1 | Chip-select driver enable (0 while sensing) |
| ee_do | output | 1 | Serial data sent to the EEPROM |
| man_rdata | output | 4 | Manual readback {ee_di, do, cs, sk} |

## Verification
The bench builds the block with `CLK_DIV` = 8 in place of 256. One complete three-word load then takes 659 cycles, so several full loads fit in a short run: five EEPROM images, an absent part, a reset in the middle of a load and the manual handover. A divisor of 8 still leaves a four-cycle high phase. This separates the rising-edge capture point from the slot boundary where `ee_do` moves, so an off-by-one sampling edge corrupts the loaded words. The default IDs are set to values that no EEPROM image contains, so a wrongly kept default is visible.

// File: rtl/eil_pkg.sv
package eil_pkg;

    typedef enum logic [2:0] {
        ST_SENSE = 3'd0,
        ST_GAP   = 3'd1,
        ST_CMD   = 3'd2,
        ST_DUMMY = 3'd3,
        ST_DATA  = 3'd4,
        ST_STORE = 3'd5,
        ST_DONE  = 3'd6
    } eil_state_e;

    // Leading bits of every read frame, sent before the word address.
    localparam logic       EIL_START_BIT = 1'b1;
    localparam logic [1:0] EIL_OP_READ   = 2'b10;

    // Manual register bit positions (write and readback share 2..0).
    localparam int MAN_SK_BIT = 0;
    localparam int MAN_CS_BIT = 1;
    localparam int MAN_DO_BIT = 2;
    localparam int MAN_DI_BIT = 3;

endpackage

// File: rtl/eil_slot_timer.sv
// Divides the system clock into serial bit slots. Within a slot the
// serial clock is low for the first half and high for the second half.
module eil_slot_timer #(
    parameter int CLK_DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic slot_end,
    output logic sk_rise,
    output logic sk_level
);
    localparam int CNT_W = $clog2(CLK_DIV);
    localparam int HALF  = CLK_DIV / 2;
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] RISE_CNT  = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] HIGH_FROM = CNT_W'(HALF);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST_CNT) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // sk_rise marks the edge at which the serial clock goes high.
    assign slot_end = run && (cnt_q == LAST_CNT);
    assign sk_rise  = run && (cnt_q == RISE_CNT);
    assign sk_level = run && (cnt_q >= HIGH_FROM);

endmodule

// File: rtl/eil_shifter.sv
// MSB-first shift register with parallel load.
module eil_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[WIDTH-2:0], ser_in};
        end
    end
endmodule

// File: rtl/eil_pin_ctrl.sv
// Pin ownership: the autoload engine before handover, the manual
// register afterwards. Manual writes are accepted only after handover.
module eil_pin_ctrl
    import eil_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       handover,
    input  logic       auto_sk,
    input  logic       auto_cs,
    input  logic       auto_do,
    input  logic       auto_oe,
    input  logic       man_we,
    input  logic [2:0] man_wdata,
    input  logic       ee_di,
    output logic       ee_sk,
    output logic       ee_cs,
    output logic       ee_cs_oe,
    output logic       ee_do,
    output logic [3:0] man_rdata
);
    logic [2:0] man_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            man_q <= '0;
        end else if (handover && man_we) begin
            man_q <= man_wdata;
        end
    end

    always_comb begin
        if (handover) begin
            ee_sk    = man_q[MAN_SK_BIT];
            ee_cs    = man_q[MAN_CS_BIT];
            ee_do    = man_q[MAN_DO_BIT];
            ee_cs_oe = 1'b1;
        end else begin
            ee_sk    = auto_sk;
            ee_cs    = auto_cs;
            ee_do    = auto_do;
            ee_cs_oe = auto_oe;
        end
    end

    always_comb begin
        man_rdata             = '0;
        man_rdata[MAN_SK_BIT] = man_q[MAN_SK_BIT];
        man_rdata[MAN_CS_BIT] = man_q[MAN_CS_BIT];
        man_rdata[MAN_DO_BIT] = man_q[MAN_DO_BIT];
        man_rdata[MAN_DI_BIT] = ee_di;
    end
endmodule

// File: rtl/eeprom_id_loader.sv
module eeprom_id_loader
    import eil_pkg::*;
#(
    parameter int                CLK_DIV       = 256,
    parameter int                WORD_W        = 16,
    parameter int                ADDR_W        = 6,
    parameter logic [WORD_W-1:0] DEF_VENDOR_ID = 'hF00D,
    parameter logic [WORD_W-1:0] DEF_SUBSYS_ID = 'h5EED,
    parameter logic [WORD_W-1:0] DEF_MODEL_ID  = 'h0A02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ee_di,
    input  logic              ee_cs_in,
    input  logic              man_we,
    input  logic [2:0]        man_wdata,
    output logic [WORD_W-1:0] vendor_id,
    output logic [WORD_W-1:0] subsys_id,
    output logic [WORD_W-1:0] model_id,
    output logic              load_done,
    output logic              ee_sk,
    output logic              ee_cs,
    output logic              ee_cs_oe,
    output logic              ee_do,
    output logic [3:0]        man_rdata
);
    localparam int NUM_WORDS = 3;
    localparam int IDX_W     = 2;
    localparam int CMD_BITS  = 3 + ADDR_W;
    localparam int CNT_MAX   = (WORD_W > CMD_BITS) ? WORD_W : CMD_BITS;
    localparam int BIT_W     = $clog2(CNT_MAX);

    eil_state_e state_q, state_n;

    logic [BIT_W-1:0]    bit_cnt_q;
    logic [IDX_W-1:0]    word_idx_q;
    logic [CMD_BITS-1:0] cmd_q;
    logic [WORD_W-1:0]   rx_q;
    logic [NUM_WORDS*WORD_W-1:0] id_bus;

    logic slot_end, sk_rise, sk_level;
    logic timer_run;
    logic auto_sk, auto_cs, auto_do, auto_oe;
    logic last_cmd, last_data, last_word;

    assign last_cmd  = (bit_cnt_q  == BIT_W'(CMD_BITS - 1));
    assign last_data = (bit_cnt_q  == BIT_W'(WORD_W - 1));
    assign last_word = (word_idx_q == IDX_W'(NUM_WORDS - 1));

    eil_slot_timer #(.CLK_DIV(CLK_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (timer_run),
        .slot_end (slot_end),
        .sk_rise  (sk_rise),
        .sk_level (sk_level)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SENSE;
        end else begin
            state_q <= state_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_SENSE: if (slot_end) state_n = ee_cs_in ? ST_GAP : ST_DONE;
            ST_GAP:   if (slot_end) state_n = ST_CMD;
            ST_CMD:   if (slot_end && last_cmd) state_n = ST_DUMMY;
            ST_DUMMY: if (slot_end) state_n = ST_DATA;
            ST_DATA:  if (slot_end && last_data) state_n = ST_STORE;
            ST_STORE: state_n = last_word ? ST_DONE : ST_GAP;
            ST_DONE:  state_n = ST_DONE;
            default:  state_n = ST_SENSE;
        endcase
    end

    // Output decode
    always_comb begin
        timer_run = 1'b0;
        auto_sk   = 1'b0;
        auto_cs   = 1'b0;
        auto_do   = 1'b0;
        auto_oe   = 1'b1;
        unique case (state_q)
            ST_SENSE: begin
                timer_run = 1'b1;
                auto_oe   = 1'b0;
            end
            ST_GAP: begin
                timer_run = 1'b1;
            end
            ST_CMD: begin
                timer_run = 1'b1;
                auto_cs   = 1'b1;
                auto_sk   = sk_level;
                auto_do   = cmd_q[CMD_BITS-1];
            end
            ST_DUMMY, ST_DATA: begin
                timer_run = 1'b1;
                auto_cs   = 1'b1;
                auto_sk   = sk_level;
            end
            ST_STORE, ST_DONE: begin
                timer_run = 1'b0;
            end
            default: begin
                timer_run = 1'b0;
            end
        endcase
    end

    // Bit and word counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
        end else if (slot_end && state_q == ST_CMD) begin
            bit_cnt_q <= last_cmd ? '0 : bit_cnt_q + 1'b1;
        end else if (slot_end && state_q == ST_DATA) begin
            bit_cnt_q <= last_data ? '0 : bit_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_idx_q <= '0;
        end else if (state_q == ST_STORE && !last_word) begin
            word_idx_q <= word_idx_q + 1'b1;
        end
    end

    // Command frame: start bit, read opcode, word address (MSB first)
    eil_shifter #(.WIDTH(CMD_BITS)) u_cmd_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_GAP && slot_end),
        .load_val ({EIL_START_BIT, EIL_OP_READ, ADDR_W'(word_idx_q)}),
        .shift    (state_q == ST_CMD && slot_end),
        .ser_in   (1'b0),
        .q        (cmd_q)
    );

    // Returned word, captured on serial clock rising edges
    eil_shifter #(.WIDTH(WORD_W)) u_rx_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (1'b0),
        .load_val ('0),
        .shift    (state_q == ST_DATA && sk_rise),
        .ser_in   (ee_di),
        .q        (rx_q)
    );

    // One ID register per word address
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_id
        localparam logic [WORD_W-1:0] RST_VAL =
            (g == 0) ? DEF_VENDOR_ID : ((g == 1) ? DEF_SUBSYS_ID : DEF_MODEL_ID);
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= RST_VAL;
            end else if (state_q == ST_STORE && word_idx_q == IDX_W'(g)) begin
                word_q <= rx_q;
            end
        end
        assign id_bus[g*WORD_W +: WORD_W] = word_q;
    end

    assign vendor_id = id_bus[0*WORD_W +: WORD_W];
    assign subsys_id = id_bus[1*WORD_W +: WORD_W];
    assign model_id  = id_bus[2*WORD_W +: WORD_W];
    assign load_done = (state_q == ST_DONE);

    eil_pin_ctrl u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .handover  (load_done),
        .auto_sk   (auto_sk),
        .auto_cs   (auto_cs),
        .auto_do   (auto_do),
        .auto_oe   (auto_oe),
        .man_we    (man_we),
        .man_wdata (man_wdata),
        .ee_di     (ee_di),
        .ee_sk     (ee_sk),
        .ee_cs     (ee_cs),
        .ee_cs_oe  (ee_cs_oe),
        .ee_do     (ee_do),
        .man_rdata (man_rdata)
    );

endmodule

// File: rtl/eil_checker.sv
module eil_checker #(
    parameter int CLK_DIV = 256,
    parameter int WORD_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_done,
    input logic              ee_sk,
    input logic              ee_cs,
    input logic              ee_cs_oe,
    input logic              ee_do,
    input logic [3:0]        man_rdata,
    input logic [WORD_W-1:0] vendor_id,
    input logic [WORD_W-1:0] subsys_id,
    input logic [WORD_W-1:0] model_id
);
    // Length of the current high phase of the serial clock
    logic [15:0] hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (ee_sk) begin
            hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    a_r3_sk_idle_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_done && !ee_cs) |-> !ee_sk);

    a_r3_sk_high_half: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ee_sk) && !load_done) |-> (hi_cnt == 16'(CLK_DIV / 2)));

    a_r4_do_steady_while_sk_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_done && ee_sk && $past(ee_sk)) |-> $stable(ee_do));

    a_r2_sense_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ee_cs_oe) |-> (!ee_sk && !load_done));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    a_r8_ids_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> ($stable(vendor_id) && $stable(subsys_id) && $stable(model_id)));

    a_r10_manual_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> (man_rdata[2:0] == 3'b000));

endmodule

bind eeprom_id_loader eil_checker #(
    .CLK_DIV (CLK_DIV),
    .WORD_W  (WORD_W)
) u_eil_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_done (load_done),
    .ee_sk     (ee_sk),
    .ee_cs     (ee_cs),
    .ee_cs_oe  (ee_cs_oe),
    .ee_do     (ee_do),
    .man_rdata (man_rdata),
    .vendor_id (vendor_id),
    .subsys_id (subsys_id),
    .model_id  (model_id)
);

// File: tb/eeprom_id_loader_bench.sv
module eeprom_id_loader_bench;
    localparam int CLK_DIV  = 8;
    localparam int WORD_W   = 16;
    localparam logic [15:0] DV = 16'hF00D;
    localparam logic [15:0] DS = 16'h5EED;
    localparam logic [15:0] DM = 16'h0A02;
    localparam int LOAD_LAT = CLK_DIV + 3 * (27 * CLK_DIV + 1);
    localparam int NVEC = 5;
    // {present, word0, word1, word2}
    localparam logic [48:0] VECS [NVEC] = '{
        {1'b1, 16'h1234, 16'hABCD, 16'h0F0F},
        {1'b1, 16'hFFFF, 16'h0000, 16'h8001},
        {1'b1, 16'hAAAA, 16'h5555, 16'h7FFE},
        {1'b0, 16'h1111, 16'h2222, 16'h3333},
        {1'b1, 16'h0000, 16'hFFFF, 16'h0001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic man_we = 1'b0;
    logic [2:0] man_wdata = 3'b000;
    logic present = 1'b1;
    logic di_man = 1'b0;
    logic model_di = 1'b0;
    logic mon_clr = 1'b1;
    logic [15:0] mem [3];

    logic ee_di, ee_cs_in;
    logic [WORD_W-1:0] vendor_id, subsys_id, model_id;
    logic load_done, ee_sk, ee_cs, ee_cs_oe, ee_do;
    logic [3:0] man_rdata;

    always #5 clk = ~clk;

    assign ee_di    = load_done ? di_man : model_di;
    assign ee_cs_in = ee_cs_oe ? ee_cs : present;

    eeprom_id_loader #(
        .CLK_DIV       (CLK_DIV),
        .WORD_W        (WORD_W),
        .ADDR_W        (6),
        .DEF_VENDOR_ID (DV),
        .DEF_SUBSYS_ID (DS),
        .DEF_MODEL_ID  (DM)
    ) u_eeprom_id_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .ee_di     (ee_di),
        .ee_cs_in  (ee_cs_in),
        .man_we    (man_we),
        .man_wdata (man_wdata),
        .vendor_id (vendor_id),
        .subsys_id (subsys_id),
        .model_id  (model_id),
        .load_done (load_done),
        .ee_sk     (ee_sk),
        .ee_cs     (ee_cs),
        .ee_cs_oe  (ee_cs_oe),
        .ee_do     (ee_do),
        .man_rdata (man_rdata)
    );

    // EEPROM model: takes command bits on rising edges and returns the word
    int rise_n;
    int cmd_n;
    logic [8:0] cmd_rx;
    logic [8:0] cmd_log [3];
    logic [15:0] out_word;
    always @(posedge ee_sk or negedge ee_cs or negedge rst_n) begin
        if (!rst_n) begin
            cmd_n = 0; rise_n = 0; model_di = 1'b0; cmd_rx = '0;
        end else if (!ee_cs) begin
            rise_n = 0; model_di = 1'b0;
        end else if (ee_sk && !load_done) begin
            rise_n++;
            if (rise_n <= 9) cmd_rx = {cmd_rx[7:0], ee_do};
            if (rise_n == 9) begin
                if (cmd_n < 3) cmd_log[cmd_n] = cmd_rx;
                cmd_n++;
                out_word = (cmd_rx[5:0] < 6'd3) ? mem[cmd_rx[1:0]] : 16'hDEAD;
                model_di = 1'b0;
            end
            if (rise_n >= 10 && rise_n <= 25) model_di = out_word[25 - rise_n];
        end
    end

    // Port monitor, sampled on the falling clock edge
    int cyc, rises, bad_period, do_bad, min_gap, lowrun, last_rise;
    bit have_rise, seen_cs, sk_p, cs_p, do_p;
    always @(negedge clk) begin
        if (mon_clr) begin
            cyc = 0; rises = 0; bad_period = 0; do_bad = 0; min_gap = 1000000;
            lowrun = 0; last_rise = 0; have_rise = 0; seen_cs = 0;
            sk_p = 0; cs_p = 0; do_p = 0;
        end else begin
            cyc++;
            if (!load_done) begin
                if (ee_sk && !sk_p) begin
                    rises++;
                    if (have_rise && (cyc - last_rise) != CLK_DIV) bad_period++;
                    last_rise = cyc; have_rise = 1;
                end
                if (ee_cs && ee_sk && sk_p && ee_do != do_p) do_bad++;
                if (!ee_cs) have_rise = 0;
                if (ee_cs && !cs_p && seen_cs && lowrun < min_gap) min_gap = lowrun;
                if (ee_cs && !cs_p) seen_cs = 1;
                if (!ee_cs && ee_cs_oe) lowrun++; else lowrun = 0;
            end
            sk_p = ee_sk; cs_p = ee_cs; do_p = ee_do;
        end
    end

    int pass_cnt = 0;
    int total_cnt = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total_cnt++;
        if (ok) pass_cnt++;
        else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; mon_clr = 1'b1; man_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; mon_clr = 1'b0;
    endtask

    // Waits for load_done; pokes the manual register once mid-load (R10)
    task automatic wait_done(output int lat, output bit sense_oe);
        lat = 0; sense_oe = 1'b1;
        while (!load_done && lat < 5000) begin
            @(negedge clk);
            lat++;
            if (lat == 2) sense_oe = ee_cs_oe;
            if (lat == 100) begin man_we = 1'b1; man_wdata = 3'b111; end
            else man_we = 1'b0;
        end
        man_we = 1'b0;
    endtask

    task automatic write_man(input logic [2:0] v);
        @(negedge clk); man_we = 1'b1; man_wdata = v;
        @(negedge clk); man_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("%0d/%0d checks passed", pass_cnt, total_cnt + 1);
        $finish;
    end

    initial begin
        int lat;
        bit soe;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(load_done == 1'b0, "R1 done", load_done, 0);
        check(ee_sk == 1'b0 && ee_cs == 1'b0, "R1 sk/cs", {ee_sk, ee_cs}, 0);
        check(ee_cs_oe == 1'b0, "R1 cs_oe", ee_cs_oe, 0);
        check(vendor_id == DV && subsys_id == DS && model_id == DM, "R1 defaults",
              {vendor_id, subsys_id, model_id}, {DV, DS, DM});

        for (int i = 0; i < NVEC; i++) begin
            logic [48:0] v;
            v = VECS[i];
            present = v[48];
            mem[0] = v[47:32]; mem[1] = v[31:16]; mem[2] = v[15:0];
            apply_reset();
            wait_done(lat, soe);
            @(negedge clk);
            check(soe == 1'b0, "R2 cs released during sense", soe, 0);
            if (present) begin
                check(lat == LOAD_LAT, "R8 done latency", lat, LOAD_LAT);
                check(vendor_id == mem[0], "R6 R5 vendor", vendor_id, mem[0]);
                check(subsys_id == mem[1], "R6 R5 subsys", subsys_id, mem[1]);
                check(model_id == mem[2], "R6 R5 model", model_id, mem[2]);
                check(cmd_n == 3, "R6 frame count", cmd_n, 3);
                for (int k = 0; k < 3; k++)
                    check(cmd_log[k] == {3'b110, 6'(k)}, "R4 command bits", cmd_log[k], {3'b110, 6'(k)});
                check(rises == 78, "R3 rise count", rises, 78);
                check(bad_period == 0, "R3 sk period", bad_period, 0);
                check(do_bad == 0, "R4 do stable while sk high", do_bad, 0);
                check(min_gap >= CLK_DIV, "R7 cs gap", min_gap, CLK_DIV);
                check(man_rdata[2:0] == 3'b000 && ee_sk == 1'b0 && ee_cs == 1'b0 && ee_do == 1'b0,
                      "R10 mid-load write ignored", {man_rdata, ee_sk, ee_cs, ee_do}, 0);
            end else begin
                check(lat == CLK_DIV, "R2 absent latency", lat, CLK_DIV);
                check(vendor_id == DV && subsys_id == DS && model_id == DM, "R2 defaults kept",
                      {vendor_id, subsys_id, model_id}, {DV, DS, DM});
                check(rises == 0, "R2 no sk pulses", rises, 0);
            end
        end

        // R11: reset in the middle of a load restarts it
        present = 1'b1;
        mem[0] = 16'hC3A5; mem[1] = 16'h0110; mem[2] = 16'hBEEF;
        apply_reset();
        repeat (300) @(negedge clk);
        check(load_done == 1'b0, "R11 still loading", load_done, 0);
        apply_reset();
        wait_done(lat, soe);
        @(negedge clk);
        check(lat == LOAD_LAT, "R11 restart latency", lat, LOAD_LAT);
        check(vendor_id == 16'hC3A5 && subsys_id == 16'h0110 && model_id == 16'hBEEF, "R11 reload",
              {vendor_id, subsys_id, model_id}, {16'hC3A5, 16'h0110, 16'hBEEF});

        // R9: manual pin control after handover
        write_man(3'b101);
        check(ee_sk == 1'b1 && ee_cs == 1'b0 && ee_do == 1'b1 && ee_cs_oe == 1'b1, "R9 pins 101",
              {ee_sk, ee_cs, ee_do, ee_cs_oe}, 4'b1011);
        di_man = 1'b1;
        @(negedge clk);
        check(man_rdata == 4'b1101, "R9 readback with di", man_rdata, 4'b1101);
        di_man = 1'b0;
        write_man(3'b010);
        check(ee_sk == 1'b0 && ee_cs == 1'b1 && ee_do == 1'b0, "R9 pins 010",
              {ee_sk, ee_cs, ee_do}, 3'b010);
        check(man_rdata == 4'b0010, "R9 readback", man_rdata, 4'b0010);
        write_man(3'b011);
        write_man(3'b010);
        check(vendor_id == 16'hC3A5 && load_done == 1'b1, "R8 ids held after bit-bang",
              {load_done, vendor_id}, {1'b1, 16'hC3A5});

        $display("%0d/%0d checks passed", pass_cnt, total_cnt);
        $finish;
    end
endmodule